// File: doc/BRIEF.md
# Phase-Offset Numerically Controlled Oscillator

This block is the phase engine of a direct digital synthesiser. On every rising edge of the master clock it adds a frequency word to a wrapping phase accumulator. Two frequency words and two phase offsets are held outside the block, and a select bit for each pair picks the one in use. The chosen 12-bit offset is added to the top accumulator bits. The result is a 12-bit phase value for a downstream amplitude lookup, together with the accumulator's most significant bit, which serves as a square-wave source. The output frequency is the clock rate times the frequency word divided by 2^28.

A select bit can change in any cycle and the accumulator is not restarted when it does. The phase therefore stays continuous for frequency-shift and phase-shift keying. A clear input forces the accumulator to the phase of a midscale output, which is zero. A hold input freezes the accumulator in place. The frequency and offset inputs keep their effect on the pipeline while hold is set. Every path from an input to an output passes through the same number of registers, so the latency is fixed and known in advance.

Top module: `nco_phase_core`

## Requirements
- R1: While `rst_n` is low, `phase_out` and `acc_msb` are 0, whatever the other inputs are.
- R2: The accumulator adds the selected word once per clock, modulo 2^28. `freq_pick`=0 selects `freq_word_a` and 1 selects `freq_word_b`. `phase_out` is accumulator bits [27:16] plus the selected offset. Bits [15:0] are truncated.
- R3: Latency is 8 rising edges. Release `acc_clear` before edge k. `phase_out` still shows the cleared phase after edge k+6, and it first shows one step of advance after edge k+7.
- R4: The accumulator wraps modulo 2^28 with no saturation. `acc_msb` is accumulator bit 27, delivered with the same latency as `phase_out`.
- R5: `ofs_pick`=0 selects `phase_ofs_a` and 1 selects `phase_ofs_b`. The selected offset is added modulo 4096. An offset change takes effect after the 8th rising edge that samples it, and not after the 7th.
- R6: Changing `freq_pick` does not restart the phase. The new step size applies from the value already reached.
- R7: While `acc_clear` is sampled high, the accumulator is held at 0 and `phase_out` equals the selected offset. The clear takes priority over `acc_hold`.
- R8: While `acc_hold` is sampled high, the accumulator keeps its value and `phase_out` stays constant (for a constant offset). After release, accumulation resumes from the frozen value.
- R9: Changes to the frequency word made while hold is active are taken in. The first advance after release uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word_a | input | 28 | Frequency word used when `freq_pick` is 0 |
| freq_word_b | input | 28 | Frequency word used when `freq_pick` is 1 |
| phase_ofs_a | input | 12 | Phase offset used when `ofs_pick` is 0 |
| phase_ofs_b | input | 12 | Phase offset used when `ofs_pick` is 1 |
| freq_pick | input | 1 | Frequency word select |
| ofs_pick | input | 1 | Phase offset select |
| acc_clear | input | 1 | Forces the accumulator to zero phase |
| acc_hold | input | 1 | Freezes the accumulator |
| phase_out | output | 12 | Offset phase value for the amplitude stage |
| acc_msb | output | 1 | Accumulator bit 27, pipelined |

## Verification
An input that is stable across rising edge k is registered at k. It reaches the accumulator at k+1 and the sum register at k+2, and it appears on the outputs after edge k+7. An accumulator value set at edge k+m is therefore visible after edge k+6+m.

The bench changes inputs only on falling edges and counts whole clock cycles from the edge where a change is sampled. It reads the outputs on the falling edge after the edge at which a result is due. For latency, offset changes and hold release, it checks both the cycle just before the new value is due and the cycle in which it arrives.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  // Per-cycle accumulator controls, registered together with the selected words
  typedef struct packed {
    logic clear;
    logic hold;
  } nco_ctl_t;
endpackage

// File: rtl/nco_in_stage.sv
`timescale 1ns/1ps
module nco_in_stage
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_a,
  input  logic [ACC_W-1:0] freq_b,
  input  logic [PH_W-1:0]  ofs_a,
  input  logic [PH_W-1:0]  ofs_b,
  input  logic             fsel,
  input  logic             osel,
  input  logic             clear_in,
  input  logic             hold_in,
  output logic [ACC_W-1:0] inc_q,
  output logic [PH_W-1:0]  ofs_q,
  output nco_ctl_t         ctl_q
);
  logic [ACC_W-1:0] inc_d;
  logic [PH_W-1:0]  ofs_d;
  nco_ctl_t         ctl_d;

  always_comb begin
    inc_d       = fsel ? freq_b : freq_a;
    ofs_d       = osel ? ofs_b : ofs_a;
    ctl_d.clear = clear_in;
    ctl_d.hold  = hold_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= '0;
      ofs_q <= '0;
      ctl_q <= '0;
    end else begin
      inc_q <= inc_d;
      ofs_q <= ofs_d;
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/nco_accum.sv
`timescale 1ns/1ps
module nco_accum
  import nco_pkg::*;
#(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  input  nco_ctl_t         ctl,
  output logic [ACC_W-1:0] acc_q
);
  logic             acc_en;
  logic [ACC_W-1:0] acc_d;

  // clear wins over hold; natural wrap modulo 2^ACC_W
  always_comb begin
    acc_en = ctl.clear | ~ctl.hold;
    acc_d  = ctl.clear ? '0 : acc_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/nco_out_pipe.sv
`timescale 1ns/1ps
module nco_out_pipe #(
  parameter int PH_W = 12,
  parameter int TAIL = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] acc_top,
  input  logic [PH_W-1:0] ofs,
  output logic [PH_W-1:0] phase,
  output logic            msb
);
  localparam int SW = PH_W + 1;

  logic [PH_W-1:0] ofs_d1;
  logic [SW-1:0]   head_d;
  logic [SW-1:0]   head_q;
  logic [SW-1:0]   last_q;

  // offset delayed one stage to line up with the accumulator update
  always_comb begin
    head_d = {acc_top[PH_W-1], acc_top + ofs_d1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_d1 <= '0;
      head_q <= '0;
    end else begin
      ofs_d1 <= ofs;
      head_q <= head_d;
    end
  end

  generate
    if (TAIL == 0) begin : g_no_tail
      assign last_q = head_q;
    end else begin : g_tail
      logic [SW-1:0] tail_q [TAIL];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < TAIL; i++) tail_q[i] <= '0;
        end else begin
          tail_q[0] <= head_q;
          for (int i = 1; i < TAIL; i++) tail_q[i] <= tail_q[i-1];
        end
      end
      assign last_q = tail_q[TAIL-1];
    end
  endgenerate

  assign phase = last_q[PH_W-1:0];
  assign msb   = last_q[SW-1];
endmodule

// File: rtl/nco_phase_core.sv
`timescale 1ns/1ps
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word_a,
  input  logic [ACC_W-1:0] freq_word_b,
  input  logic [PH_W-1:0]  phase_ofs_a,
  input  logic [PH_W-1:0]  phase_ofs_b,
  input  logic             freq_pick,
  input  logic             ofs_pick,
  input  logic             acc_clear,
  input  logic             acc_hold,
  output logic [PH_W-1:0]  phase_out,
  output logic             acc_msb
);
  // input register, accumulator and sum register are fixed stages
  localparam int TAIL = LAT - 3;

  logic [ACC_W-1:0] sel_inc;
  logic [PH_W-1:0]  sel_ofs;
  nco_ctl_t         sel_ctl;
  logic             sel_clr;
  logic             sel_hold;
  logic [ACC_W-1:0] acc_val;

  nco_in_stage #(.ACC_W(ACC_W), .PH_W(PH_W)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .freq_a   (freq_word_a),
    .freq_b   (freq_word_b),
    .ofs_a    (phase_ofs_a),
    .ofs_b    (phase_ofs_b),
    .fsel     (freq_pick),
    .osel     (ofs_pick),
    .clear_in (acc_clear),
    .hold_in  (acc_hold),
    .inc_q    (sel_inc),
    .ofs_q    (sel_ofs),
    .ctl_q    (sel_ctl)
  );

  assign sel_clr  = sel_ctl.clear;
  assign sel_hold = sel_ctl.hold;

  nco_accum #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (sel_inc),
    .ctl   (sel_ctl),
    .acc_q (acc_val)
  );

  nco_out_pipe #(.PH_W(PH_W), .TAIL(TAIL)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_top (acc_val[ACC_W-1 -: PH_W]),
    .ofs     (sel_ofs),
    .phase   (phase_out),
    .msb     (acc_msb)
  );
endmodule

// File: rtl/nco_phase_core_chk.sv
`timescale 1ns/1ps
module nco_phase_core_chk #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] inc_q,
  input logic             clr_q,
  input logic             hold_q,
  input logic [ACC_W-1:0] acc_q,
  input logic [PH_W-1:0]  phase_out,
  input logic             acc_msb
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (phase_out == '0 && acc_msb == 1'b0)
        else $error("R1 outputs not zero in reset");
    end
  end

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> acc_q == '0);

  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !clr_q) |=> $stable(acc_q));

  assert_accum_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !clr_q) |=> acc_q == ACC_W'($past(acc_q) + $past(inc_q)));
endmodule

bind nco_phase_core nco_phase_core_chk #(.ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inc_q     (sel_inc),
  .clr_q     (sel_clr),
  .hold_q    (sel_hold),
  .acc_q     (acc_val),
  .phase_out (phase_out),
  .acc_msb   (acc_msb)
);

// File: tb/test_nco_phase_core.sv
`timescale 1ns/1ps
module test_nco_phase_core;
  logic        clk;
  logic        rst_n;
  logic [27:0] freq_word_a, freq_word_b;
  logic [11:0] phase_ofs_a, phase_ofs_b;
  logic        freq_pick, ofs_pick, acc_clear, acc_hold;
  logic [11:0] phase_out;
  logic        acc_msb;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  nco_phase_core i_nco_phase_core (
    .clk(clk), .rst_n(rst_n),
    .freq_word_a(freq_word_a), .freq_word_b(freq_word_b),
    .phase_ofs_a(phase_ofs_a), .phase_ofs_b(phase_ofs_b),
    .freq_pick(freq_pick), .ofs_pick(ofs_pick),
    .acc_clear(acc_clear), .acc_hold(acc_hold),
    .phase_out(phase_out), .acc_msb(acc_msb)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // clear for long enough to flush the pipe, then release; next rising edge is k
  task automatic restart(input logic [27:0] fa, input logic [27:0] fb,
                         input logic [11:0] oa, input logic [11:0] ob,
                         input logic fs, input logic os);
    freq_word_a = fa; freq_word_b = fb;
    phase_ofs_a = oa; phase_ofs_b = ob;
    freq_pick = fs; ofs_pick = os;
    acc_hold = 0; acc_clear = 1;
    step(10);
    acc_clear = 0;
  endtask

  task automatic t_reset;
    freq_word_a = 28'h1230000; phase_ofs_a = 12'h456;
    step(3);
    chk("R1 phase", phase_out, 12'h000);
    chk("R1 msb", {11'd0, acc_msb}, 12'h000);
    rst_n = 1;
  endtask

  task automatic t_ramp;
    restart(28'h0010000, 28'h0, 12'h0, 12'h0, 0, 0);
    step(6);  chk("R3 before due", phase_out, 12'd0);
    step(1);  chk("R3 cleared value", phase_out, 12'd0);
    step(1);  chk("R3 first advance", phase_out, 12'd1);
    step(3);  chk("R2 ramp", phase_out, 12'd4);
    restart(28'h0010000, 28'h0020000, 12'h0, 12'h0, 1, 0);
    step(12); chk("R2 word b", phase_out, 12'd10);
    restart(28'h0004000, 28'h0, 12'h0, 12'h0, 0, 0);
    step(16); chk("R2 truncation", phase_out, 12'd2);
  endtask

  task automatic t_wrap;
    restart(28'h8000000, 28'h0, 12'h0, 12'h0, 0, 0);
    step(8);  chk("R4 half phase", phase_out, 12'h800);
              chk("R4 msb high", {11'd0, acc_msb}, 12'd1);
    step(1);  chk("R4 wrap", phase_out, 12'h000);
              chk("R4 msb low", {11'd0, acc_msb}, 12'd0);
    restart(28'hFFF0000, 28'h0, 12'h0, 12'h0, 0, 0);
    step(9);  chk("R4 modulo", phase_out, 12'hFFE);
  endtask

  task automatic t_offset;
    freq_word_a = 28'h0010000; phase_ofs_a = 12'h123; phase_ofs_b = 12'hABC;
    freq_pick = 0; ofs_pick = 0; acc_hold = 0; acc_clear = 1;
    step(10); chk("R7 clear shows offset", phase_out, 12'h123);
    ofs_pick = 1;
    step(7);  chk("R5 old offset at 7", phase_out, 12'h123);
    step(1);  chk("R5 new offset at 8", phase_out, 12'hABC);
    restart(28'h0010000, 28'h0, 12'h0, 12'hFFF, 0, 1);
    step(7);  chk("R5 offset b", phase_out, 12'hFFF);
    step(1);  chk("R5 offset wrap", phase_out, 12'h000);
  endtask

  task automatic t_fsk;
    restart(28'h0010000, 28'h0030000, 12'h0, 12'h0, 0, 0);
    step(4);
    freq_pick = 1;
    step(7);  chk("R6 before switch", phase_out, 12'd4);
    step(1);  chk("R6 continuous", phase_out, 12'd7);
    step(1);  chk("R6 new step", phase_out, 12'd10);
  endtask

  task automatic t_hold;
    restart(28'h0010000, 28'h0, 12'h0, 12'h0, 0, 0);
    step(3);
    acc_hold = 1;
    step(12); chk("R8 frozen", phase_out, 12'd3);
    freq_word_a = 28'h0020000;
    step(1);  chk("R8 still frozen", phase_out, 12'd3);
    acc_hold = 0;
    step(7);  chk("R8 before resume", phase_out, 12'd3);
    step(1);  chk("R9 new word after hold", phase_out, 12'd5);
    acc_hold = 1; acc_clear = 1;
    step(10); chk("R7 clear over hold", phase_out, 12'd0);
    acc_hold = 0; acc_clear = 0;
  endtask

  initial begin
    rst_n = 1;
    freq_word_a = 0; freq_word_b = 0; phase_ofs_a = 0; phase_ofs_b = 0;
    freq_pick = 0; ofs_pick = 0; acc_clear = 0; acc_hold = 0;
    #1 rst_n = 0;
    @(negedge clk);
    t_reset;
    t_ramp;
    t_wrap;
    t_offset;
    t_fsk;
    t_hold;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule